// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter built around a charge-balance capacitor array. The analog input multiplexer, the sample-and-hold switch, the capacitor array and the comparator sit outside the block. The block drives the channel select, the sample/hold control and the 10-bit trial code for the array. It reads back one comparator bit and builds the result from it.

Software turns the converter on with a separate enable input. A single write to the control register then supplies the input channel and the sample-time class, and starts the conversion. The block holds the sampling switch closed for a share of the selected time. It then resolves the ten bits one after another, most significant first, with equal time for each bit. When it finishes it stores the code across two read registers, sets an end-of-conversion flag and pulses an interrupt.

All timing is counted in module clocks. A time unit is `UNIT_CLKS` clocks. A conversion lasts 4, 8, 16 or 32 units. Nothing else in the system changes the conversion speed.

Top module: `sar_adc_top`

## Requirements
- R1: After reset, `ctrlRd` reads 0x80 (done flag set, result 0), `resHiRd` reads 0, and `irq`, `sampleHold`, `chanSel` and `dacCode` are all 0.
- R2: A `ctrlWr` pulse is accepted when `enable` is 1, the done flag (`ctrlRd[7]`) is 1, and channel field `wrData[3:0]` is below 15. On the next cycle `chanSel` equals that channel, `ctrlRd[7]` is 0 and `sampleHold` is 1.
- R3: A write whose channel field is 15 starts nothing. The read registers and `sampleHold` are unchanged, and `chanSel` never shows a value above 14.
- R4: A write while `enable` is 0, or while a conversion is running, is ignored. A running conversion keeps its channel, its timing and its result.
- R5: Sample-time field `wrData[5:4]` codes 0, 1, 2 and 3 select 4, 8, 16 and 32 units. `ctrlRd[7]` returns to 1 exactly N = UNIT_CLKS·4·2^code clock edges after the accepting edge.
- R6: `sampleHold` stays high for exactly S = N − 10·B clocks after acceptance, where B = (N − (N >> SAMPLE_SHIFT)) / 10 (integer division). Each of the ten bit trials then lasts B clocks, and `dacCode` is 0 while sampling.
- R7: The trials run most significant bit first, so the first trial code is 512. A bit is kept when `cmpIn` is 1, and `cmpIn` is 1 when the input is at or above the trial code. With an ideal comparator, the result equals the input code.
- R8: `resHiRd` holds result bits 9:2. `ctrlRd[1:0]` holds result bits 1:0, `ctrlRd[7]` is the done flag and `ctrlRd[6:2]` reads 0.
- R9: `irq` is high for exactly one clock, in the first cycle in which the done flag is set again after a completed conversion.
- R10: When `enable` goes low, `sampleHold`, `dacCode` and `chanSel` go to 0 on the next edge. A running conversion is aborted: the done flag is set, no `irq` is raised, and the previous result is kept.
- R11: While a conversion runs, `resHiRd`, `ctrlRd[1:0]` and `chanSel` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, also the conversion time base |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter power/enable bit from the system register |
| ctrlWr | input | 1 | Write strobe for the control register |
| wrData | input | 8 | Write data: [3:0] channel, [5:4] sample-time class |
| ctrlRd | output | 8 | Control read: [7] done flag, [1:0] result LSBs |
| resHiRd | output | 8 | Result bits 9:2 |
| chanSel | output | 4 | Analog multiplexer select |
| sampleHold | output | 1 | 1 = sampling switch closed |
| dacCode | output | 10 | Trial code for the capacitor array, 0 when not trialling |
| cmpIn | input | 1 | Comparator: 1 when input is at or above trial code |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Every input code from 0 to 1023 is converted, so the bench catches a wrong bit order, a bit kept on the wrong comparator polarity, or a lost code at 0 or at full scale. Each channel is swept at all four time classes. In each conversion the bench counts the cycles to completion and the cycles of sampling, so an off-by-one counter reload or a wrong time-class decode shows up as a wrong count. A second write during a conversion, a write with channel 15 and a write while disabled are each sent. A design that accepted any of them would change the channel or restart the timing. A disable in the middle of a conversion must leave the old result in place, set the done flag and raise no interrupt.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic start;    // accepted conversion request
    logic trialOn;  // a bit trial is being presented
    logic resolve;  // last cycle of a trial: decide the bit
    logic lastBit;  // the trial being resolved is bit 0
    logic abort;    // conversion cancelled by disable
  } seqStrobe_t;

  function automatic int convClks(int unitClks, int sel);
    return unitClks * (4 << sel);
  endfunction

  function automatic int trialClks(int unitClks, int shift, int resBits, int sel);
    int n;
    n = convClks(unitClks, sel);
    return (n - (n >> shift)) / resBits;
  endfunction

  function automatic int sampClks(int unitClks, int shift, int resBits, int sel);
    return convClks(unitClks, sel) - resBits * trialClks(unitClks, shift, resBits, sel);
  endfunction

endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int NUM_CH       = 15,
  parameter int UNIT_CLKS    = 10,
  parameter int SAMPLE_SHIFT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       ctrlWr,
  input  logic [3:0] wrCh,
  input  logic [1:0] wrSel,
  output seqStrobe_t strb,
  output logic       sampleHold
);

  localparam int MAX_CLKS = 32 * UNIT_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam int BIT_W    = $clog2(RES_BITS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [BIT_W-1:0] BIT_ONE = BIT_W'(1);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(RES_BITS - 1);
  localparam logic [4:0]       CH_LIM  = 5'(NUM_CH);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_TRIAL} seqState_t;

  logic [CNT_W-1:0] sampLen [4];
  logic [CNT_W-1:0] bitLen  [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign sampLen[g] = CNT_W'(sampClks(UNIT_CLKS, SAMPLE_SHIFT, RES_BITS, g));
    assign bitLen[g]  = CNT_W'(trialClks(UNIT_CLKS, SAMPLE_SHIFT, RES_BITS, g));
  end

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitsLeft;
  logic [1:0]       selQ;
  logic             accept;
  logic             cntZero;

  assign accept  = enable && ctrlWr && (state == ST_IDLE) && ({1'b0, wrCh} < CH_LIM);
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitsLeft <= '0;
      selQ     <= '0;
    end else if (!enable) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitsLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_SAMPLE;
            cnt   <= sampLen[wrSel] - CNT_ONE;
            selQ  <= wrSel;
          end
        end
        ST_SAMPLE: begin
          if (cntZero) begin
            state    <= ST_TRIAL;
            cnt      <= bitLen[selQ] - CNT_ONE;
            bitsLeft <= BIT_TOP;
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        ST_TRIAL: begin
          if (cntZero) begin
            if (bitsLeft == '0) begin
              state <= ST_IDLE;
            end else begin
              bitsLeft <= bitsLeft - BIT_ONE;
              cnt      <= bitLen[selQ] - CNT_ONE;
            end
          end else begin
            cnt <= cnt - CNT_ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.start   = accept;
    strb.trialOn = (state == ST_TRIAL);
    strb.resolve = (state == ST_TRIAL) && cntZero && enable;
    strb.lastBit = strb.resolve && (bitsLeft == '0);
    strb.abort   = !enable && (state != ST_IDLE);
  end

  assign sampleHold = (state == ST_SAMPLE);

endmodule

// File: rtl/sar_adc_dp.sv
module sar_adc_dp
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  seqStrobe_t          strb,
  input  logic [3:0]          wrCh,
  input  logic                cmpIn,
  output logic [3:0]          chanSel,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] result,
  output logic                eoc,
  output logic                irq
);

  localparam logic [RES_BITS-1:0] MSB_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] acc;
  logic [RES_BITS-1:0] mask;
  logic [RES_BITS-1:0] trialCode;
  logic [RES_BITS-1:0] decided;

  assign trialCode = acc | mask;
  assign decided   = cmpIn ? trialCode : acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanSel <= '0;
      acc     <= '0;
      mask    <= '0;
      result  <= '0;
      eoc     <= 1'b1;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!enable) begin
        chanSel <= '0;
        acc     <= '0;
        mask    <= '0;
        if (strb.abort) eoc <= 1'b1;
      end else if (strb.start) begin
        chanSel <= wrCh;
        acc     <= '0;
        mask    <= MSB_MASK;
        eoc     <= 1'b0;
      end else if (strb.resolve) begin
        acc  <= decided;
        mask <= mask >> 1;
        if (strb.lastBit) begin
          result <= decided;
          eoc    <= 1'b1;
          irq    <= 1'b1;
        end
      end
    end
  end

  assign dacCode = strb.trialOn ? trialCode : '0;

endmodule

// File: rtl/sar_adc_top.sv
module sar_adc_top
  import sar_adc_pkg::*;
#(
  parameter int NUM_CH       = 15,
  parameter int UNIT_CLKS    = 10,
  parameter int SAMPLE_SHIFT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       ctrlWr,
  input  logic [7:0] wrData,
  output logic [7:0] ctrlRd,
  output logic [7:0] resHiRd,
  output logic [3:0] chanSel,
  output logic       sampleHold,
  output logic [9:0] dacCode,
  input  logic       cmpIn,
  output logic       irq
);

  localparam int RES_BITS = 10;

  seqStrobe_t          strb;
  logic [RES_BITS-1:0] result;
  logic                eoc;

  sar_adc_seq #(
    .RES_BITS(RES_BITS), .NUM_CH(NUM_CH),
    .UNIT_CLKS(UNIT_CLKS), .SAMPLE_SHIFT(SAMPLE_SHIFT)
  ) u_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .ctrlWr(ctrlWr),
    .wrCh(wrData[3:0]), .wrSel(wrData[5:4]),
    .strb(strb), .sampleHold(sampleHold)
  );

  sar_adc_dp #(.RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb),
    .wrCh(wrData[3:0]), .cmpIn(cmpIn),
    .chanSel(chanSel), .dacCode(dacCode), .result(result),
    .eoc(eoc), .irq(irq)
  );

  assign ctrlRd  = {eoc, 5'b00000, result[1:0]};
  assign resHiRd = result[9:2];

endmodule

// File: rtl/sar_adc_checker.sv
module sar_adc_checker #(
  parameter int NUM_CH = 15
) (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       ctrlWr,
  input logic [7:0] wrData,
  input logic [7:0] ctrlRd,
  input logic [7:0] resHiRd,
  input logic [3:0] chanSel,
  input logic       sampleHold,
  input logic [9:0] dacCode,
  input logic       irq
);

  localparam logic [4:0] CH_LIM = 5'(NUM_CH);

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && ctrlWr && ctrlRd[7] && ({1'b0, wrData[3:0]} < CH_LIM))
      |=> (!ctrlRd[7] && sampleHold && chanSel == $past(wrData[3:0]))); // R2

  AST_BAD_CHANNEL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlRd[7] && ({1'b0, wrData[3:0]} >= CH_LIM))
      |=> (ctrlRd[7] && !sampleHold)); // R3

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, chanSel} < CH_LIM)); // R3

  AST_NO_TRIAL_WHILE_SAMPLING: assert property (@(posedge clk) disable iff (!rstN)
    sampleHold |-> (dacCode == '0)); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R9

  AST_IRQ_ON_DONE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlRd[7] && !$past(ctrlRd[7]))); // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sampleHold && dacCode == '0 && chanSel == '0 && !irq)); // R10

  AST_BUSY_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[7] && $past(!ctrlRd[7]))
      |-> ($stable(resHiRd) && $stable(ctrlRd[1:0]) && $stable(chanSel))); // R11

endmodule

bind sar_adc_top sar_adc_checker #(.NUM_CH(NUM_CH)) chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ctrlWr(ctrlWr), .wrData(wrData),
  .ctrlRd(ctrlRd), .resHiRd(resHiRd), .chanSel(chanSel),
  .sampleHold(sampleHold), .dacCode(dacCode), .irq(irq)
);

// File: tb/sar_adc_top_test.sv
module sar_adc_top_test;

  localparam int UNIT = 10;
  localparam int SHIFT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] ctrlRd, resHiRd;
  logic [3:0] chanSel;
  logic       sampleHold, cmpIn, irq;
  logic [9:0] dacCode;
  logic [9:0] vinArr [16];

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // ideal comparator against the selected input
  assign cmpIn = (vinArr[chanSel] >= dacCode);

  sar_adc_top #(.NUM_CH(15), .UNIT_CLKS(UNIT), .SAMPLE_SHIFT(SHIFT)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ctrlWr(ctrlWr), .wrData(wrData),
    .ctrlRd(ctrlRd), .resHiRd(resHiRd), .chanSel(chanSel),
    .sampleHold(sampleHold), .dacCode(dacCode), .cmpIn(cmpIn), .irq(irq)
  );

  function automatic int expN(int sel);
    return UNIT * (4 << sel);
  endfunction
  function automatic int expB(int sel);
    return (expN(sel) - (expN(sel) >> SHIFT)) / 10;
  endfunction
  function automatic int expS(int sel);
    return expN(sel) - 10 * expB(sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCtrl(input int ch, input int sel);
    wrData = {2'b00, 2'(sel), 4'(ch)};
    ctrlWr = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  // one conversion; intrudeAt >= 0 sends a second write at that cycle
  task automatic runConv(input int ch, input int sel, input int vin, input int intrudeAt);
    int cnt, sampHi, irqCnt, firstTrial;
    bit seenTrial;
    vinArr[ch] = 10'(vin);
    writeCtrl(ch, sel);
    check(!ctrlRd[7] && sampleHold && chanSel == 4'(ch), "R2 start", int'(ctrlRd[7]), 0);
    cnt = 0; sampHi = 0; irqCnt = 0; seenTrial = 1'b0; firstTrial = 0;
    while (!ctrlRd[7] && cnt < 2000) begin
      if (sampleHold) sampHi++;
      if (irq) irqCnt++;
      if (!sampleHold && !seenTrial) begin
        seenTrial = 1'b1;
        firstTrial = int'(dacCode);
      end
      if (chanSel != 4'(ch)) check(1'b0, "R11 channel held", int'(chanSel), ch);
      cnt++;
      if (cnt == intrudeAt) begin
        wrData = {2'b00, 2'(3 - sel), 4'((ch + 3) % 15)};
        ctrlWr = 1'b1;
      end else begin
        ctrlWr = 1'b0;
      end
      @(negedge clk);
    end
    ctrlWr = 1'b0;
    check(cnt == expN(sel), "R5 conversion length", cnt, expN(sel));
    check(sampHi == expS(sel), "R6 sample length", sampHi, expS(sel));
    check(firstTrial == 512, "R7 first trial code", firstTrial, 512);
    check(int'(resHiRd) == (vin >> 2), "R7 R8 result high", int'(resHiRd), vin >> 2);
    check(int'(ctrlRd[1:0]) == (vin & 3) && ctrlRd[6:2] == '0, "R8 result low",
          int'(ctrlRd), 128 + (vin & 3));
    check(irq && irqCnt == 0, "R9 irq at done", int'(irq), 1);
    @(negedge clk);
    check(!irq, "R9 irq single", int'(irq), 0);
    if (intrudeAt >= 0)
      check(chanSel == 4'(ch), "R4 busy write ignored", int'(chanSel), ch);
  endtask

  task automatic ignoredWrite(input int ch, input int sel, input string req);
    logic [7:0] c0, h0;
    c0 = ctrlRd; h0 = resHiRd;
    writeCtrl(ch, sel);
    repeat (3) begin
      check(ctrlRd == c0 && resHiRd == h0 && !sampleHold && dacCode == '0, req,
            int'(ctrlRd), int'(c0));
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) vinArr[i] = '0;
    @(negedge clk);
    @(negedge clk);
    check(ctrlRd == 8'h80 && resHiRd == 0 && !irq && !sampleHold && chanSel == 0 &&
          dacCode == 0, "R1 reset state", int'(ctrlRd), 128);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRd == 8'h80 && resHiRd == 0, "R1 after release", int'(ctrlRd), 128);

    ignoredWrite(3, 0, "R4 write while disabled");
    enable = 1'b1;
    @(negedge clk);
    ignoredWrite(15, 0, "R3 channel 15 ignored");

    // every code at the shortest time class
    for (int v = 0; v < 1024; v++) runConv(5, 0, v, -1);

    // every channel at every time class
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 15; c++)
        runConv(c, s, (c == 0) ? 0 : (c == 14) ? 1023 : (c * 73 + s * 211 + 17) % 1024, -1);

    // second write during a conversion, at several points
    runConv(2, 1, 700, 3);
    runConv(9, 0, 1, 20);
    runConv(14, 3, 1022, 200);

    // abort by disable
    runConv(4, 2, 333, -1);
    vinArr[6] = 10'd900;
    writeCtrl(6, 1);
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(ctrlRd[7] && !sampleHold && dacCode == 0 && chanSel == 0 && !irq,
          "R10 abort quiet", int'(ctrlRd), 128);
    check(int'(resHiRd) == (333 >> 2) && int'(ctrlRd[1:0]) == (333 & 3),
          "R10 result kept", int'(resHiRd), 333 >> 2);
    @(negedge clk);
    check(!irq, "R10 no irq on abort", int'(irq), 0);
    ignoredWrite(6, 1, "R4 disabled after abort");
    enable = 1'b1;
    @(negedge clk);
    runConv(6, 1, 900, -1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule